// File: doc/BRIEF.md
# Limit-Compare Interval Timer Bank

This block is a set of microsecond interval timers reached through one 32-bit word-addressed register port. One instance serves the whole system and drives the level-10 interrupt line. Each CPU has one more instance, and each of these drives its own level-14 line. All instances advance on a shared one-cycle tick enable that pulses once per microsecond. Each instance has a count field and a limit field, and both sit left-justified in bits [30:10] of their words. Software writes a limit of (interval + 1) << 10. When an increment carries the count up to the limit, the count falls back to 1 and the interrupt goes high. It stays high until software reads the limit word.

Each instance holds a small two-state machine named FIRE_IDLE and FIRE_HELD. The reach transition moves it from FIRE_IDLE to FIRE_HELD when an enabled tick carries the count to the limit. The acknowledge transition moves it back from FIRE_HELD to FIRE_IDLE on a read of the limit word. If a reach happens in the same cycle as that read, the reach wins. A second limit alias lets software reprogram the interval without acknowledging. A run bit lets software freeze a counter.

Top module: `lct_timer_bank`

## Requirements
- R1: After reset every interrupt output is low. Every count field holds 1 and every limit field holds 0. Every run bit reads 1.
- R2: Each tick enable seen by a running instance adds one to its count field. The count field is read at word offset 1, bits [30:10].
- R3: The limit field is at offset 0, bits [30:10]. On a tick where count+1 is at least a nonzero limit, the count becomes 1 and the instance enters FIRE_HELD, so the interrupt rises after max(1, limit-1) ticks.
- R4: A read of offset 0 returns the limit word and takes the instance back to FIRE_IDLE, which lowers the interrupt. A reach in the same cycle keeps it in FIRE_HELD.
- R5: A write to offset 2 updates the limit and leaves a held interrupt high. A read of offset 2 returns the limit and leaves a held interrupt high.
- R6: A write to offset 0 or 2 reloads the count field with 1. This takes precedence over a tick in the same cycle.
- R7: With a limit of 0 the counter keeps counting and never raises its interrupt.
- R8: Bit 0 of the run word freezes the counter when it is 0. For a per-CPU instance the run word is at offset 3. For the global instance it is at offset 4.
- R9: Bit 31 of the count word reads 1 exactly while the instance is in FIRE_HELD, and reading the count word does not clear it. Writes to the count word are ignored. The global offset 3, per-CPU offsets 4 to 7, and addresses of absent instances all read 0.
- R10: Address bits [2:0] select the word and the upper bits select the instance. Instance 0 is global and drives irq_lvl10. Instance k drives irq_lvl14[k-1]. Read data appears on bus_rdata one cycle after bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_1us | input | 1 | One-cycle pulse per microsecond |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | IDX_W+3 | Word address: instance, then word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_lvl10 | output | 1 | Global timer interrupt |
| irq_lvl14 | output | NCPU | Per-CPU timer interrupts |

## Verification
The bench builds the bank with NCPU = 2, which gives three instances, and keeps the 21-bit field at bit 10. This lets it sweep every instance against every limit from 1 to 6 and check each intermediate count and the exact tick of each reach. The small instance count also lets every out-of-range address be read. Limits this small make both the period floor at limit 1 and 2 and the simultaneous read-and-reach case quick to reach.

// File: rtl/lct_pkg.sv
package lct_pkg;
    localparam logic [2:0] OFF_LIMIT    = 3'd0;
    localparam logic [2:0] OFF_COUNT    = 3'd1;
    localparam logic [2:0] OFF_LIMIT_NC = 3'd2;
    localparam logic [2:0] OFF_CTRL     = 3'd3;
    localparam logic [2:0] OFF_CONFIG   = 3'd4;

    typedef enum logic {
        FIRE_IDLE = 1'b0,
        FIRE_HELD = 1'b1
    } fire_e;
endpackage

// File: rtl/lct_core.sv
module lct_core
    import lct_pkg::*;
#(
    parameter bit IS_GLOBAL = 1'b0,
    parameter int FIELD_LSB = 10,
    parameter int FIELD_W   = 21
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        sel,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [2:0]  off,
    input  logic [31:0] wdata,
    output logic [31:0] rd_word,
    output logic        irq
);
    localparam logic [FIELD_W-1:0] ONE     = FIELD_W'(1);
    localparam logic [2:0]         RUN_OFF = IS_GLOBAL ? OFF_CONFIG : OFF_CTRL;

    fire_e              state_q, state_d;
    logic [FIELD_W-1:0] cnt_q, lim_q, cnt_inc;
    logic               run_q;
    logic               wr_lim, wr_run, ack, step, reach;

    assign wr_lim  = sel && wr_en && (off == OFF_LIMIT || off == OFF_LIMIT_NC);
    assign wr_run  = sel && wr_en && (off == RUN_OFF);
    assign ack     = sel && rd_en && (off == OFF_LIMIT);
    assign step    = tick && run_q;
    assign cnt_inc = cnt_q + ONE;
    assign reach   = step && !wr_lim && (lim_q != '0) && (cnt_inc >= lim_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FIRE_IDLE: if (reach)         state_d = FIRE_HELD;
            FIRE_HELD: if (ack && !reach) state_d = FIRE_IDLE;
            default:                      state_d = FIRE_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FIRE_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= ONE;
            lim_q <= '0;
            run_q <= 1'b1;
        end else begin
            if (wr_lim)      lim_q <= wdata[FIELD_LSB +: FIELD_W];
            if (wr_run)      run_q <= wdata[0];
            if (wr_lim)      cnt_q <= ONE;
            else if (reach)  cnt_q <= ONE;
            else if (step)   cnt_q <= cnt_inc;
        end
    end

    // outputs
    always_comb begin
        irq     = (state_q == FIRE_HELD);
        rd_word = '0;
        unique case (off)
            OFF_LIMIT, OFF_LIMIT_NC: rd_word[FIELD_LSB +: FIELD_W] = lim_q;
            OFF_COUNT: begin
                rd_word[FIELD_LSB +: FIELD_W] = cnt_q;
                rd_word[31]                   = (state_q == FIRE_HELD);
            end
            OFF_CTRL:   if (!IS_GLOBAL) rd_word[0] = run_q;
            OFF_CONFIG: if (IS_GLOBAL)  rd_word[0] = run_q;
            default:    rd_word = '0;
        endcase
    end

    // R3
    fire_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reach |=> irq);
    // R4
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !reach) |=> !irq);
    // R5
    alias_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && off == OFF_LIMIT_NC && irq && !ack) |=> irq);
    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lim |=> (cnt_q == ONE));
    // R7
    free_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_q == '0 && !irq) |=> !irq);
    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_lim) |=> $stable(cnt_q));
endmodule

// File: rtl/lct_rdmux.sv
module lct_rdmux #(
    parameter int N     = 3,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0][31:0] words,
    input  logic [IDX_W-1:0]   idx,
    output logic [31:0]        word
);
    always_comb begin
        word = '0;
        for (int k = 0; k < N; k++) begin
            if (idx == IDX_W'(k)) word = words[k];
        end
    end
endmodule

// File: rtl/lct_timer_bank.sv
module lct_timer_bank #(
    parameter int NCPU      = 2,
    parameter int FIELD_LSB = 10,
    parameter int FIELD_W   = 21,
    parameter int IDX_W     = $clog2(NCPU + 1),
    parameter int AW        = IDX_W + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_1us,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            irq_lvl10,
    output logic [NCPU-1:0] irq_lvl14
);
    localparam int NINST = NCPU + 1;

    logic [NINST-1:0][31:0] words;
    logic [NINST-1:0]       irqs;
    logic [IDX_W-1:0]       idx;
    logic [2:0]             off;
    logic [31:0]            mux_word;

    assign idx = bus_addr[AW-1:3];
    assign off = bus_addr[2:0];

    for (genvar g = 0; g < NINST; g++) begin : g_inst
        lct_core #(
            .IS_GLOBAL (g == 0),
            .FIELD_LSB (FIELD_LSB),
            .FIELD_W   (FIELD_W)
        ) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick_1us),
            .sel     (idx == IDX_W'(g)),
            .wr_en   (bus_wr),
            .rd_en   (bus_rd),
            .off     (off),
            .wdata   (bus_wdata),
            .rd_word (words[g]),
            .irq     (irqs[g])
        );
    end

    lct_rdmux #(.N(NINST), .IDX_W(IDX_W)) u_mux (
        .words (words),
        .idx   (idx),
        .word  (mux_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= mux_word;
    end

    assign irq_lvl10 = irqs[0];
    assign irq_lvl14 = irqs[NINST-1:1];

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_lct_timer_bank.sv
module sim_lct_timer_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1us = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_lvl10;
    logic [1:0]  irq_lvl14;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lct_timer_bank #(.NCPU(2)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_lvl10(irq_lvl10), .irq_lvl14(irq_lvl14)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit w, input bit r, input bit t, input int idx,
                       input int off, input logic [31:0] d);
        @(negedge clk);
        bus_wr = w; bus_rd = r; tick_1us = t;
        bus_addr = 5'((idx << 3) | off);
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; tick_1us = 1'b0;
    endtask

    function automatic logic [31:0] irqv();
        return {29'd0, irq_lvl14, irq_lvl10};
    endfunction

    function automatic logic [31:0] fld(input int v);
        return 32'(v) << 10;
    endfunction

    task automatic rd(input int idx, input int off);
        cyc(1'b0, 1'b1, 1'b0, idx, off, '0);
    endtask

    task automatic wr(input int idx, input int off, input logic [31:0] d);
        cyc(1'b1, 1'b0, 1'b0, idx, off, d);
    endtask

    task automatic tk();
        cyc(1'b0, 1'b0, 1'b1, 0, 7, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irqs", irqv(), 32'd0);
        for (int i = 0; i < 3; i++) begin
            rd(i, 1); chk("R1 count", bus_rdata, fld(1));
            rd(i, 0); chk("R1 limit", bus_rdata, 32'd0);
        end
        rd(0, 4); chk("R1 global run", bus_rdata, 32'd1);
        rd(1, 3); chk("R1 cpu run", bus_rdata, 32'd1);
        rd(2, 3); chk("R1 cpu run", bus_rdata, 32'd1);

        // R2 R3 R4 R10 sweep every instance and limit
        for (int i = 0; i < 3; i++) begin
            for (int L = 1; L <= 6; L++) begin
                int p;
                p = (L > 2) ? L - 1 : 1;
                wr(i, 0, fld(L));
                rd(i, 0); chk("R3 limit readback", bus_rdata, fld(L));
                chk("R3 idle", irqv(), 32'd0);
                for (int t = 1; t < p; t++) begin
                    tk(); chk("R3 no early irq", irqv(), 32'd0);
                    rd(i, 1); chk("R2 count", bus_rdata, fld(t + 1));
                end
                tk(); chk("R10 irq line", irqv(), 32'(1 << i));
                rd(i, 1); chk("R9 flag and count", bus_rdata, 32'h8000_0000 | fld(1));
                chk("R9 count read keeps irq", irqv(), 32'(1 << i));
                rd(i, 0); chk("R4 ack readback", bus_rdata, fld(L));
                chk("R4 ack clears", irqv(), 32'd0);
            end
            wr(i, 0, 32'd0);
        end

        // R7 free running
        rd(2, 1); c0 = bus_rdata;
        for (int t = 0; t < 5; t++) tk();
        rd(2, 1); chk("R7 free count", bus_rdata, c0 + fld(5));
        chk("R7 no irq", irqv(), 32'd0);

        // R9 write to count ignored, reserved words zero
        wr(2, 1, 32'hFFFF_FFFF);
        rd(2, 1); chk("R9 count write ignored", bus_rdata, c0 + fld(5));
        rd(0, 3); chk("R9 global reserved", bus_rdata, 32'd0);
        rd(1, 4); chk("R9 cpu offset4", bus_rdata, 32'd0);
        rd(1, 5); chk("R9 cpu offset5", bus_rdata, 32'd0);
        rd(3, 0); chk("R9 absent instance", bus_rdata, 32'd0);

        // R5 R6 non-clearing alias
        wr(1, 0, fld(2));
        tk(); chk("R5 fired", irqv(), 32'd2);
        wr(1, 2, fld(5));
        chk("R5 alias keeps irq", irqv(), 32'd2);
        rd(1, 1); chk("R6 alias reloads count", bus_rdata, 32'h8000_0000 | fld(1));
        rd(1, 2); chk("R5 alias readback", bus_rdata, fld(5));
        chk("R5 alias read keeps irq", irqv(), 32'd2);
        rd(1, 0); chk("R5 new limit", bus_rdata, fld(5));
        chk("R4 cleared", irqv(), 32'd0);

        // R4 read and reach in same cycle
        wr(1, 0, fld(2));
        tk(); chk("R4 fired", irqv(), 32'd2);
        cyc(1'b0, 1'b1, 1'b1, 1, 0, '0);
        chk("R4 reach wins over ack", irqv(), 32'd2);
        rd(1, 0); chk("R4 later ack clears", irqv(), 32'd0);

        // R6 write beats tick
        wr(1, 0, fld(6));
        tk(); tk();
        rd(1, 1); chk("R6 pre count", bus_rdata, fld(3));
        cyc(1'b1, 1'b0, 1'b1, 1, 0, fld(6));
        rd(1, 1); chk("R6 write beats tick", bus_rdata, fld(1));

        // R8 run control
        wr(1, 3, 32'd0);
        rd(1, 3); chk("R8 cpu run off", bus_rdata, 32'd0);
        for (int t = 0; t < 3; t++) tk();
        rd(1, 1); chk("R8 cpu frozen", bus_rdata, fld(1));
        wr(1, 3, 32'd1);
        tk();
        rd(1, 1); chk("R8 cpu resumes", bus_rdata, fld(2));
        rd(0, 1); c0 = bus_rdata;
        wr(0, 4, 32'd0);
        rd(0, 4); chk("R8 global run off", bus_rdata, 32'd0);
        tk(); tk();
        rd(0, 1); chk("R8 global frozen", bus_rdata, c0);
        wr(0, 4, 32'd1);
        tk();
        rd(0, 1); chk("R8 global resumes", bus_rdata, c0 + fld(1));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule